// File: doc/BRIEF.md
# Delayed Read Target Controller

This block handles reads on the target side of a PCI-style bus. An external master presents an address and a command. The block passes the read to an internal fetch port and waits for the response. If the data comes back soon enough, the block completes the bus transaction with that data. If not, it ends the transaction with a retry. The read stays outstanding inside the block while the master is away.

Once the fetched data arrives, the block keeps it for the master that made the request. That master returns with the same address and command. The data is held until that master comes back or a programmable lifetime runs out, whichever happens first. While the single buffer is in use, any other read receives a retry and starts no fetch. The lifetime is set through a small register write port, and its value can be read back.

Top module: `dly_read_tgt`

## Requirements
- R1: If fetch data arrives within 16 clocks of the clock edge that accepts a new read (edges 1 to 16 after it), the read completes in the same transaction: `tgt_ready_o` pulses with the fetched data and `tgt_stop_o` stays low.
- R2: If no fetch data has arrived by the 16th edge after acceptance, `tgt_stop_o` pulses (retry) and the read stays outstanding.
- R3: Each newly accepted read raises `fetch_req_o` for exactly one cycle. A read that is served from held data or retried raises no fetch.
- R4: A read whose address and command both equal the outstanding read's, arriving while its data is held, completes at once with the held data. The buffer is then free, so the next identical read starts a new fetch.
- R5: A read that differs in address or command, arriving while the buffer is pending or holding data, receives a retry and starts no fetch.
- R6: A matching read that arrives before the fetch data has come back receives a retry.
- R7: The lifetime timer is loaded when the retry is issued and counts bus clocks. When it runs out before the master returns, the held data is discarded, and the same read later starts a fresh fetch.
- R8: The lifetime value is 16 bits wide, resets to 0x8000 and reads back through `cfg_rdata_o[15:0]` after a write.
- R9: Bits 31:16 of `cfg_rdata_o` always read zero, and writes to those bits have no effect.
- R10: `tgt_ready_o` and `tgt_stop_o` are single-cycle pulses and are never high together.
- R11: If the lifetime runs out while the fetch is still pending, every read receives a retry until the late data arrives. That data is then dropped and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_req_i | input | 1 | Master holds a read request until it sees ready or stop |
| tgt_addr_i | input | 32 | Read address |
| tgt_cmd_i | input | 4 | Bus command of the read |
| tgt_ready_o | output | 1 | Pulse: read completed, data valid |
| tgt_stop_o | output | 1 | Pulse: retry, master must come back later |
| tgt_data_o | output | 32 | Read data, valid with `tgt_ready_o` |
| fetch_req_o | output | 1 | One-cycle internal fetch request |
| fetch_addr_o | output | 32 | Fetch address |
| fetch_cmd_o | output | 4 | Fetch command |
| fetch_valid_i | input | 1 | Fetch response valid |
| fetch_data_i | input | 32 | Fetch response data |
| cfg_we_i | input | 1 | Lifetime register write enable |
| cfg_wdata_i | input | 32 | Lifetime register write data |
| cfg_rdata_o | output | 32 | Lifetime register read value |

## Verification
The bench places fetch responses at 16 and 17 clocks after acceptance. A design whose retry decision is off by one edge either retries a read that should have completed or completes one that should have been retried. It sends a read that differs from the held one only in its command, which catches a design that compares only addresses and hands one master's data to another. It lets the lifetime expire both after the data arrives and before it arrives. A design that mishandles expiry would serve stale data, lose track of the late response, or hang the next fetch. It also counts fetch requests around every served or retried read, which exposes a design that refetches on a retry.

// File: rtl/dly_read_pkg.sv
package dly_read_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,   // fetch pending, master still on the bus
    ST_PEND,   // retried, fetch still pending
    ST_HOLD,   // data held for the original master
    ST_FLUSH   // lifetime gone, absorbing a late response
  } st_e;
endpackage

// File: rtl/dly_read_life_reg.sv
module dly_read_life_reg #(
  parameter int unsigned      LW  = 16,
  parameter int unsigned      CW  = 32,
  parameter logic [LW-1:0]    RST = 16'h8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [LW-1:0] life_o,
  output logic [CW-1:0] rdata_o
);
  logic [LW-1:0] life_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   life_q <= RST;
    else if (we_i) life_q <= wdata_i[LW-1:0];
  end

  assign life_o  = life_q;
  assign rdata_o = {{(CW-LW){1'b0}}, life_q};

  // R8
  life_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_o[LW-1:0] == $past(wdata_i[LW-1:0]));
endmodule

// File: rtl/dly_read_wait_cnt.sv
module dly_read_wait_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT) + 1;
  logic [CW-1:0] cnt_q;

  assign hit_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end

  // R2
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT - 1));
  // R2
  wait_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !hit_o) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/dly_read_life_tmr.sv
module dly_read_life_tmr #(
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] load_val_i,
  input  logic          run_i,
  output logic          last_o
);
  logic [LW-1:0] cnt_q;

  // zero behaves as one clock
  assign last_o = (cnt_q <= LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (run_i && !last_o)   cnt_q <= cnt_q - 1'b1;
  end

  // R7
  life_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !last_o) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/dly_read_tgt.sv
module dly_read_tgt
  import dly_read_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   DW        = 32,
  parameter int unsigned   CMW       = 4,
  parameter int unsigned   RETRY_CYC = 16,
  parameter int unsigned   LIFE_W    = 16,
  parameter int unsigned   CFG_W     = 32,
  parameter logic [15:0]   LIFE_RST  = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgt_req_i,
  input  logic [AW-1:0]    tgt_addr_i,
  input  logic [CMW-1:0]   tgt_cmd_i,
  output logic             tgt_ready_o,
  output logic             tgt_stop_o,
  output logic [DW-1:0]    tgt_data_o,
  output logic             fetch_req_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic [CMW-1:0]   fetch_cmd_o,
  input  logic             fetch_valid_i,
  input  logic [DW-1:0]    fetch_data_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o
);
  st_e              st_q, st_d;
  logic [AW-1:0]    hold_addr_q;
  logic [CMW-1:0]   hold_cmd_q;
  logic [DW-1:0]    hold_data_q;
  logic             rdy_q, rdy_d, stp_q, stp_d, cap;
  logic [DW-1:0]    dout_q, dout_d;
  logic [LIFE_W-1:0] life;
  logic             acc, match, whit, tload, trun, tlast;

  dly_read_life_reg #(.LW(LIFE_W), .CW(CFG_W), .RST(LIFE_W'(LIFE_RST))) i_life_reg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .life_o(life), .rdata_o(cfg_rdata_o));

  dly_read_wait_cnt #(.LIMIT(RETRY_CYC)) i_wait_cnt (
    .clk_i, .rst_ni, .clr_i(fetch_req_o), .inc_i(st_q == ST_WAIT), .hit_o(whit));

  dly_read_life_tmr #(.LW(LIFE_W)) i_life_tmr (
    .clk_i, .rst_ni, .load_i(tload), .load_val_i(life), .run_i(trun), .last_o(tlast));

  // a request is new only when no response is on the bus this cycle
  assign acc   = tgt_req_i && !rdy_q && !stp_q;
  assign match = acc && (tgt_addr_i == hold_addr_q) && (tgt_cmd_i == hold_cmd_q);

  assign fetch_req_o  = (st_q == ST_IDLE) && acc;
  assign fetch_addr_o = tgt_addr_i;
  assign fetch_cmd_o  = tgt_cmd_i;

  assign tload = (st_q == ST_WAIT) && !fetch_valid_i && whit;
  assign trun  = (st_q == ST_PEND) || (st_q == ST_HOLD);

  always_comb begin
    st_d   = st_q;
    rdy_d  = 1'b0;
    stp_d  = 1'b0;
    dout_d = '0;
    cap    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (acc) st_d = ST_WAIT;
      ST_WAIT: begin
        if (fetch_valid_i) begin
          rdy_d  = 1'b1;
          dout_d = fetch_data_i;
          st_d   = ST_IDLE;
        end else if (whit) begin
          stp_d = 1'b1;
          st_d  = ST_PEND;
        end
      end
      ST_PEND: begin
        stp_d = acc;
        if (tlast)              st_d = fetch_valid_i ? ST_IDLE : ST_FLUSH;
        else if (fetch_valid_i) begin
          st_d = ST_HOLD;
          cap  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (match) begin
          rdy_d  = 1'b1;
          dout_d = hold_data_q;
          st_d   = ST_IDLE;
        end else begin
          stp_d = acc;
          if (tlast) st_d = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        stp_d = acc;
        if (fetch_valid_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rdy_q       <= 1'b0;
      stp_q       <= 1'b0;
      dout_q      <= '0;
      hold_addr_q <= '0;
      hold_cmd_q  <= '0;
      hold_data_q <= '0;
    end else begin
      st_q   <= st_d;
      rdy_q  <= rdy_d;
      stp_q  <= stp_d;
      dout_q <= dout_d;
      if (fetch_req_o) begin
        hold_addr_q <= tgt_addr_i;
        hold_cmd_q  <= tgt_cmd_i;
      end
      if (cap) hold_data_q <= fetch_data_i;
    end
  end

  assign tgt_ready_o = rdy_q;
  assign tgt_stop_o  = stp_q;
  assign tgt_data_o  = dout_q;

  // R10
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tgt_ready_o && tgt_stop_o));
  // R10
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ready_o |=> !tgt_ready_o);
  // R10
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_stop_o |=> !tgt_stop_o);
  // R3
  fetch_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> !fetch_req_o);
  // R5
  foreign_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && acc && !match) |=> (tgt_stop_o && !tgt_ready_o));
  // R1
  fast_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && fetch_valid_i) |=> (tgt_ready_o && tgt_data_o == $past(fetch_data_i)));
endmodule

// File: tb/test_dly_read_tgt.sv
module test_dly_read_tgt;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [7:0]  dly;
    logic        retry;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h1000_0040, 4'h6, 8'd1,  1'b0},
    '{32'h2000_0100, 4'h2, 8'd5,  1'b0},
    '{32'h3000_0008, 4'h6, 8'd16, 1'b0},
    '{32'h4000_0010, 4'hA, 8'd17, 1'b1},
    '{32'h5000_0abc, 4'h6, 8'd25, 1'b1},
    '{32'h6000_0004, 4'h2, 8'd15, 1'b0}
  };

  logic        clk = 0, rst_n = 0;
  logic        req = 0;
  logic [31:0] addr = '0;
  logic [3:0]  cmd = '0;
  logic        fvalid = 0;
  logic [31:0] fdata = '0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic        tgt_ready_o, tgt_stop_o, fetch_req_o;
  logic [31:0] tgt_data_o, fetch_addr_o, cfg_rdata_o;
  logic [3:0]  fetch_cmd_o;

  int total = 0, bad = 0, fetch_cnt = 0, fetch_dly = 1;
  bit finished = 0;

  always #5 clk = ~clk;

  dly_read_tgt i_dly_read_tgt (
    .clk_i(clk), .rst_ni(rst_n),
    .tgt_req_i(req), .tgt_addr_i(addr), .tgt_cmd_i(cmd),
    .tgt_ready_o, .tgt_stop_o, .tgt_data_o,
    .fetch_req_o, .fetch_addr_o, .fetch_cmd_o,
    .fetch_valid_i(fvalid), .fetch_data_i(fdata),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [3:0] c,
                         output logic r, output logic s, output logic [31:0] d);
    @(negedge clk);
    req = 1; addr = a; cmd = c;
    r = 0; s = 0; d = '0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tgt_ready_o || tgt_stop_o) begin
        r = tgt_ready_o; s = tgt_stop_o; d = tgt_data_o;
        break;
      end
    end
    req = 0;
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // fetch responder: one outstanding fetch, answer after fetch_dly clocks
  initial begin
    logic [31:0] fa;
    forever begin
      @(negedge clk);
      #1;
      if (fetch_req_o) begin
        fetch_cnt++;
        fa = fetch_addr_o;
        repeat (fetch_dly) @(negedge clk);
        fvalid = 1; fdata = fa ^ KEY;
        @(negedge clk);
        fvalid = 0; fdata = '0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic r, s;
    logic [31:0] d;
    int f0;

    repeat (3) @(negedge clk);
    // reset state (R8, R10)
    chk(!tgt_ready_o && !tgt_stop_o && !fetch_req_o, "R10 reset outputs",
        {29'b0, tgt_ready_o, tgt_stop_o, fetch_req_o}, 32'h0);
    chk(cfg_rdata_o == 32'h0000_8000, "R8 reset lifetime", cfg_rdata_o, 32'h0000_8000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // vector walk: R1 within window, R2 beyond it, R3 retried read not refetched
    foreach (VEC[k]) begin
      fetch_dly = int'(VEC[k].dly);
      f0 = fetch_cnt;
      do_read(VEC[k].addr, VEC[k].cmd, r, s, d);
      if (!VEC[k].retry) begin
        chk(r && !s, "R1 completes in window", {30'b0, r, s}, 32'h2);
        chk(d == (VEC[k].addr ^ KEY), "R1 data", d, VEC[k].addr ^ KEY);
      end else begin
        chk(s && !r, "R2 retry after window", {30'b0, r, s}, 32'h1);
        repeat (VEC[k].dly + 2) @(negedge clk);
        do_read(VEC[k].addr, VEC[k].cmd, r, s, d);
        chk(r && d == (VEC[k].addr ^ KEY), "R4 held data served", d, VEC[k].addr ^ KEY);
      end
      chk(fetch_cnt == f0 + 1, "R3 one fetch per read", fetch_cnt, f0 + 1);
      repeat (3) @(negedge clk);
    end

    // R5: foreign reads while data held; R4: buffer freed after match
    fetch_dly = 20;
    f0 = fetch_cnt;
    do_read(32'hA000_0000, 4'h6, r, s, d);
    repeat (25) @(negedge clk);
    do_read(32'hB000_0000, 4'h6, r, s, d);
    chk(s && !r, "R5 other address retried", {30'b0, r, s}, 32'h1);
    do_read(32'hA000_0000, 4'h2, r, s, d);
    chk(s && !r, "R5 other command retried", {30'b0, r, s}, 32'h1);
    chk(fetch_cnt == f0 + 1, "R5 no fetch for foreign read", fetch_cnt, f0 + 1);
    do_read(32'hA000_0000, 4'h6, r, s, d);
    chk(r && d == (32'hA000_0000 ^ KEY), "R4 match served", d, 32'hA000_0000 ^ KEY);
    fetch_dly = 2;
    do_read(32'hA000_0000, 4'h6, r, s, d);
    chk(fetch_cnt == f0 + 2 && r, "R4 buffer freed, new fetch", fetch_cnt, f0 + 2);

    // R6: matching read before data returns
    fetch_dly = 30;
    f0 = fetch_cnt;
    do_read(32'hC000_0020, 4'h6, r, s, d);
    do_read(32'hC000_0020, 4'h6, r, s, d);
    chk(s && !r, "R6 early match retried", {30'b0, r, s}, 32'h1);
    repeat (30) @(negedge clk);
    do_read(32'hC000_0020, 4'h6, r, s, d);
    chk(r && d == (32'hC000_0020 ^ KEY), "R6 later served", d, 32'hC000_0020 ^ KEY);
    chk(fetch_cnt == f0 + 1, "R3 no refetch on retries", fetch_cnt, f0 + 1);

    // R9 upper bits ignored, R8 readback
    cfg_write(32'hFFFF_000A);
    @(negedge clk);
    chk(cfg_rdata_o == 32'h0000_000A, "R9 upper bits zero", cfg_rdata_o, 32'h0000_000A);

    // R7: lifetime expiry after data held
    fetch_dly = 20;
    f0 = fetch_cnt;
    do_read(32'hD000_0000, 4'h6, r, s, d);
    chk(s, "R2 retry before expiry test", {30'b0, r, s}, 32'h1);
    repeat (40) @(negedge clk);
    fetch_dly = 2;
    do_read(32'hD000_0000, 4'h6, r, s, d);
    chk(fetch_cnt == f0 + 2, "R7 expired data refetched", fetch_cnt, f0 + 2);
    chk(r && d == (32'hD000_0000 ^ KEY), "R7 fresh data", d, 32'hD000_0000 ^ KEY);

    // R11: expiry while fetch still pending
    cfg_write(32'h0000_0005);
    fetch_dly = 40;
    f0 = fetch_cnt;
    do_read(32'hE000_0000, 4'h6, r, s, d);
    repeat (8) @(negedge clk);
    do_read(32'hF000_0000, 4'h6, r, s, d);
    chk(s && !r, "R11 retry while flushing", {30'b0, r, s}, 32'h1);
    chk(fetch_cnt == f0 + 1, "R11 no fetch while flushing", fetch_cnt, f0 + 1);
    repeat (40) @(negedge clk);
    fetch_dly = 3;
    do_read(32'hE000_0000, 4'h6, r, s, d);
    chk(fetch_cnt == f0 + 2 && r, "R11 idle after late data", fetch_cnt, f0 + 2);
    chk(d == (32'hE000_0000 ^ KEY), "R11 data", d, 32'hE000_0000 ^ KEY);

    // R8: restore and read back
    cfg_write(32'h0000_8000);
    @(negedge clk);
    chk(cfg_rdata_o == 32'h0000_8000, "R8 readback", cfg_rdata_o, 32'h0000_8000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule